// File: doc/BRIEF.md
# Enable-Indexed Serial Test Pattern Source

This block drives one serial line with a fixed bit sequence meant as stimulus for a shift register under test. An internal up-counter measures how many rising clock edges have passed since the run input went high. The output bit is a decode of that count: it is 0 on eight chosen positions early in the run and 1 everywhere else.

The run input does two jobs. Its low level clears the counter at once, without waiting for a clock edge. Its high level lets the counter advance by one on each rising edge. A dedicated reset pin is not needed. Dropping the run input and raising it again replays the sequence from the start.

The counter is 8 bits wide by default. It stops at its top value, so after the short sequence the line stays at 1 for as long as the run input is held high.

Top module: `serpat_top`

## Requirements
- R1: While run_en_i is low, the internal count is 0. A falling edge on run_en_i forces the count to 0 without waiting for a clock edge, so pat_o reads 0 within the same clock phase.
- R2: While run_en_i is high, the count rises by exactly one on every rising edge of clk_i, until it reaches the top value.
- R3: pat_o is 0 whenever the count is one of 0, 1, 5, 7, 8, 10, 18 or 20.
- R4: pat_o is 1 for every count value outside the set listed in R3.
- R5: Once the count reaches 2^CNT_W-1 (255 by default), it holds that value for as long as run_en_i stays high, and pat_o stays 1.
- R6: Each time run_en_i is raised again after a low period, the sequence restarts from count 0, whatever the count was before it was cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock that advances the count |
| run_en_i | input | 1 | High: count advances. Low: count cleared at once |
| pat_o | output | 1 | Serial pattern bit decoded from the current count |

## Verification
The step and hold properties assume that run_en_i changes away from the rising edge of clk_i. If a release landed on an edge, it would be unclear whether that edge counts. The stimulus therefore moves run_en_i only a few nanoseconds after a rising edge, including the asynchronous drops placed at random points within long runs. The run lengths and low periods are drawn at random from a fixed seed. Directed runs cover the whole first sequence, the rise into saturation, and restarts from both short and saturated counts.

// File: rtl/serpat_pkg.sv
package serpat_pkg;

  // Default counter width
  localparam int unsigned CNT_W = 8;

  // Count positions at which the serial line is driven low
  localparam int unsigned N_LOW = 8;
  localparam int unsigned LOW_IDX [N_LOW] = '{0, 1, 5, 7, 8, 10, 18, 20};

endpackage

// File: rtl/serpat_counter.sv
module serpat_counter #(
  parameter int unsigned W        = serpat_pkg::CNT_W,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk_i,
  input  logic         run_en_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_max;

  assign at_max = &cnt_q;

  // Next-state logic: the build-time choice selects stop-at-top or wrap-around
  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        cnt_d = cnt_q;
        if (!at_max) cnt_d = cnt_q + ONE;
      end
    end else begin : g_wrap
      always_comb begin
        cnt_d = cnt_q + ONE;
      end
    end
  endgenerate

  // State register: a low run input is the asynchronous clear
  always_ff @(posedge clk_i or negedge run_en_i) begin
    if (!run_en_i) cnt_q <= '0;
    else           cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: the count is zero at any edge where the run input is low
  a_r1_clear_low: assert property (@(posedge clk_i)
    !run_en_i |-> (cnt_q == '0));

  // R2: the count advances by one per edge below the top value
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!run_en_i)
    !at_max |=> (cnt_q == $past(cnt_q) + ONE));

  generate
    if (SATURATE) begin : g_sat_chk
      // R5: the top value is held
      a_r5_hold_top: assert property (@(posedge clk_i) disable iff (!run_en_i)
        at_max |=> at_max);
    end
  endgenerate

endmodule

// File: rtl/serpat_decode.sv
module serpat_decode #(
  parameter int unsigned W = serpat_pkg::CNT_W
) (
  input  logic [W-1:0] cnt_i,
  output logic         pat_o
);

  localparam int unsigned N = serpat_pkg::N_LOW;

  logic [N-1:0] hit;

  // One comparator for each low position
  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = (cnt_i == W'(serpat_pkg::LOW_IDX[g]));
    end
  endgenerate

  assign pat_o = ~|hit;

endmodule

// File: rtl/serpat_top.sv
module serpat_top #(
  parameter int unsigned CNT_W    = serpat_pkg::CNT_W,
  parameter bit          SATURATE = 1'b1
) (
  input  logic clk_i,
  input  logic run_en_i,
  output logic pat_o
);

  logic [CNT_W-1:0] cnt;

  serpat_counter #(
    .W        (CNT_W),
    .SATURATE (SATURATE)
  ) i_counter (
    .clk_i    (clk_i),
    .run_en_i (run_en_i),
    .cnt_o    (cnt)
  );

  serpat_decode #(
    .W (CNT_W)
  ) i_decode (
    .cnt_i (cnt),
    .pat_o (pat_o)
  );

  // R3: the first position of every run is low
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!run_en_i)
    (cnt == '0) |-> !pat_o);

  // R4: beyond the last low position the line is high
  a_r4_tail_high: assert property (@(posedge clk_i) disable iff (!run_en_i)
    (cnt > CNT_W'(20)) |-> pat_o);

endmodule

// File: tb/test_serpat_top.sv
module test_serpat_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  TOP        = 255;

  logic clk;
  logic run_en;
  logic pat;

  int n_checks;
  int n_errors;
  int k;

  serpat_top i_serpat_top (
    .clk_i    (clk),
    .run_en_i (run_en),
    .pat_o    (pat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit exp_bit(input int idx);
    case (idx)
      0, 1, 5, 7, 8, 10, 18, 20: return 1'b0;
      default:                   return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input bit expv);
    n_checks++;
    if (pat !== expv) begin
      n_errors++;
      $display("FAIL %s at %0t: pat_o=%b expected %b (index %0d)", req, $time, pat, expv, k);
    end
  endtask

  // One enabled cycle: sample mid-cycle, then step the bench index
  task automatic run_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, exp_bit(k));
      @(posedge clk);
      if (k < TOP) k++;
    end
  endtask

  task automatic raise_en();
    @(posedge clk);
    #2ns;
    run_en = 1'b1;
    k = 0;
  endtask

  task automatic drop_en();
    @(posedge clk);
    #2ns;
    run_en = 1'b0;
    k = 0;
    #1ns;
    check("R1 async clear", 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    k        = 0;
    run_en   = 1'b1;
    void'($urandom(32'h5EED_0042));
    #1ns;
    run_en = 1'b0;

    // Held low: output stays at the index-0 value
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 held low", 1'b0);
    end

    // Full sequence and the rise into saturation
    raise_en();
    run_cycles(31, "R2/R3/R4 sequence");
    run_cycles(260, "R5 saturation");

    // Restart after saturation
    drop_en();
    repeat (2) begin
      @(negedge clk);
      check("R1 low after drop", 1'b0);
    end
    raise_en();
    run_cycles(25, "R6 restart after top");

    // Random runs with asynchronous drops at random points
    for (int ep = 0; ep < 40; ep++) begin
      int run_len;
      int low_len;
      run_len = 1 + int'($urandom_range(0, 60));
      low_len = int'($urandom_range(0, 4));
      drop_en();
      for (int i = 0; i < low_len; i++) begin
        @(negedge clk);
        check("R1 random low", 1'b0);
      end
      raise_en();
      run_cycles(run_len, "R6 random restart");
    end

    // Restart from a short count
    drop_en();
    raise_en();
    run_cycles(4, "R6 short restart");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200_000 * CLK_PERIOD);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule